// File: doc/BRIEF.md
# Transmit Pending Flag Register with Atomic Word-Pair Access

This block holds one transmit-pending flag per mailbox in a 32-bit vector and drives that vector straight to the transmit scheduler. Software reaches the vector over a 16-bit peripheral bus at two word addresses. One address selects the upper half, for mailboxes 31 to 16. The other selects the lower half, for mailboxes 15 to 1. Mailbox 0 has no flag.

A single 16-bit holding latch makes a 32-bit access through two word accesses behave as one atomic operation.

- **Write:** a write to the upper word is parked in the latch. The following lower-word write then sets flags in both halves in one clock.
- **Read:** a read of the upper word returns the live upper half and copies the live lower half into the latch. The following lower-word read returns that copy.

Software can only set flags, by writing ones. Flags are removed by a cancel-request vector or a transmit-complete vector from the mailbox engine. A per-mailbox transmit-enable mask blocks set requests for mailboxes that are not configured to transmit.

Top module: `txpend_reg`

## Requirements
- R1: After reset the pending vector, the read data and the holding latch are all zero.
- R2: A write with word select 0 (upper word) stores its data in the holding latch and leaves the pending vector unchanged.
- R3: A write with word select 1 (lower word) forms the 32-bit value {latch, write data}. In the next cycle, every pending bit whose position holds a 1 in that value is set. Positions holding 0 leave their flag unchanged.
- R4: A set request for a bit whose transmit-enable mask bit is 0 is ignored.
- R5: Bit 0 of the pending vector is always 0, so bit 0 of a lower-word read is always 0.
- R6: A 1 on a bit of the cancel-request input or the transmit-complete input clears that pending bit in the next cycle. The clear wins over a set aimed at the same bit in the same cycle.
- R7: A read with word select 0 returns bits 31:16 of the pending vector one cycle later. In the same cycle it copies bits 15:0 into the latch. The next read with word select 1 returns that copy even if the flags have changed since.
- R8: A lower-word access that does not directly follow an upper-word access uses the latch as it stands, whatever access last loaded it.
- R9: Read data changes only one cycle after a read. At all other times it holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_vld | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | Word select: 0 = upper half, 1 = lower half |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read |
| tx_en_mask | input | 32 | Per-mailbox transmit-enable mask |
| cancel_req | input | 32 | Per-mailbox cancel request, clears flags |
| tx_done | input | 32 | Per-mailbox transmit complete, clears flags |
| pend_o | output | 32 | Pending vector to the transmit scheduler |

## Verification
The assertions take for granted that every input is a known value at each rising edge. They also assume that `bus_wr` and `bus_addr` carry meaning only while `bus_vld` is high. Under those terms, a one-cycle lookback is enough to relate the pending vector, the mask and the clear inputs.

The stimulus changes all inputs one time unit after the rising edge and never drives X. Every access is a single-cycle strobe. Between accesses the bench returns `bus_vld`, `cancel_req` and `tx_done` to zero, so each check sees the effect of exactly the cycle it intends.

// File: rtl/txpend_reg.sv
module txpend_reg #(
  parameter int WW   = 16,
  parameter int NBOX = 2 * WW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_vld,
  input  logic            bus_wr,
  input  logic            bus_addr,
  input  logic [WW-1:0]   bus_wdata,
  output logic [WW-1:0]   bus_rdata,
  input  logic [NBOX-1:0] tx_en_mask,
  input  logic [NBOX-1:0] cancel_req,
  input  logic [NBOX-1:0] tx_done,
  output logic [NBOX-1:0] pend_o
);

  localparam logic [NBOX-1:0] SLOT_OK = ~{{(NBOX-1){1'b0}}, 1'b1};

  logic [NBOX-1:0] pend_q;
  logic [WW-1:0]   hold_q;
  logic [WW-1:0]   rdata_q;

  wire up_wr = bus_vld &&  bus_wr && !bus_addr;
  wire lo_wr = bus_vld &&  bus_wr &&  bus_addr;
  wire up_rd = bus_vld && !bus_wr && !bus_addr;
  wire lo_rd = bus_vld && !bus_wr &&  bus_addr;

  wire [NBOX-1:0] set_vec = lo_wr ? ({hold_q, bus_wdata} & tx_en_mask & SLOT_OK) : '0;
  wire [NBOX-1:0] clr_vec = cancel_req | tx_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      hold_q  <= '0;
      rdata_q <= '0;
    end else begin
      pend_q <= (pend_q | set_vec) & ~clr_vec & SLOT_OK;
      if (up_wr)      hold_q <= bus_wdata;
      else if (up_rd) hold_q <= pend_q[WW-1:0];
      if (up_rd)      rdata_q <= pend_q[NBOX-1:WW];
      else if (lo_rd) rdata_q <= hold_q;
    end
  end

  assign pend_o    = pend_q;
  assign bus_rdata = rdata_q;

endmodule

// File: rtl/txpend_reg_chk.sv
module txpend_reg_chk #(
  parameter int WW   = 16,
  parameter int NBOX = 2 * WW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_vld,
  input logic            bus_wr,
  input logic            bus_addr,
  input logic [WW-1:0]   bus_wdata,
  input logic [WW-1:0]   bus_rdata,
  input logic [NBOX-1:0] tx_en_mask,
  input logic [NBOX-1:0] cancel_req,
  input logic [NBOX-1:0] tx_done,
  input logic [NBOX-1:0] pend_o
);

  p_slot0_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o[0] == 1'b0);

  p_set_only_by_low_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_vld && bus_wr && bus_addr) |=> ((pend_o & ~$past(pend_o)) == '0));

  p_masked_set_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(tx_en_mask)) == '0));

  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cancel_req | tx_done) != '0) |=> ((pend_o & $past(cancel_req | tx_done)) == '0));

  p_upper_read_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && !bus_wr && !bus_addr) |=> (bus_rdata == $past(pend_o[NBOX-1:WW])));

  p_rdata_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_vld && !bus_wr) |=> $stable(bus_rdata));

endmodule

bind txpend_reg txpend_reg_chk #(.WW(WW), .NBOX(NBOX)) u_chk (.*);

// File: tb/txpend_reg_tb.sv
`timescale 1ns/1ps
module txpend_reg_tb;
  logic        clk = 0, rst_n = 0;
  logic        bus_vld = 0, bus_wr = 0, bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic [31:0] tx_en_mask = '1, cancel_req = 0, tx_done = 0, pend_o;

  int total = 0, bad = 0;
  logic [31:0] m_pend = 0;
  logic [15:0] m_hold = 0, m_rd = 0;

  always #2 clk = ~clk;

  txpend_reg u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    logic [31:0] setv;
    @(posedge clk); #1;
    setv = 0;
    if (bus_vld && !bus_wr && !bus_addr) begin m_rd = m_pend[31:16]; m_hold = m_pend[15:0]; end
    else if (bus_vld && !bus_wr && bus_addr) m_rd = m_hold;
    if (bus_vld && bus_wr && bus_addr) setv = {m_hold, bus_wdata} & tx_en_mask & 32'hFFFF_FFFE;
    if (bus_vld && bus_wr && !bus_addr) m_hold = bus_wdata;
    m_pend = (m_pend | setv) & ~(cancel_req | tx_done);
    chk({tag, " pend"}, pend_o, m_pend);
    chk({tag, " rdata"}, {16'h0, bus_rdata}, {16'h0, m_rd});
  endtask

  task automatic op(string tag, logic v, logic w, logic a, logic [15:0] d);
    bus_vld = v; bus_wr = w; bus_addr = a; bus_wdata = d;
    cyc(tag);
    bus_vld = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    cancel_req = 0; tx_done = 0;
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 pend", pend_o, 0);
    chk("R1 rdata", {16'h0, bus_rdata}, 0);
    op("R2", 1, 1, 0, 16'hA5A5);
    chk("R2 upper write parked", pend_o, 0);
    op("R3", 1, 1, 1, 16'h00FF);
    chk("R3 pair write", pend_o, 32'hA5A5_00FE);
    chk("R5 bit0", {31'h0, pend_o[0]}, 0);
    op("R3", 1, 1, 0, 16'h0000);
    op("R3", 1, 1, 1, 16'h0000);
    chk("R3 zeros no effect", pend_o, 32'hA5A5_00FE);
    cancel_req = 32'h0000_0002; op("R6", 0, 0, 0, 0);
    chk("R6 cancel", pend_o, 32'hA5A5_00FC);
    tx_done = 32'h8000_0000; op("R6", 0, 0, 0, 0);
    chk("R6 done", pend_o, 32'h25A5_00FC);
    op("R6", 1, 1, 0, 16'h0000);
    cancel_req = 32'h0000_0100; op("R6", 1, 1, 1, 16'h0100);
    chk("R6 clear beats set", pend_o, 32'h25A5_00FC);
    op("R8", 1, 1, 1, 16'h0100);
    chk("R8 lone lower write", pend_o, 32'h25A5_01FC);
    cancel_req = '1; op("R6", 0, 0, 0, 0);
    chk("R6 all clear", pend_o, 0);
    tx_en_mask = 32'h0F0F_F0F0;
    op("R4", 1, 1, 0, 16'hFFFF);
    op("R4", 1, 1, 1, 16'hFFFF);
    chk("R4 mask", pend_o, 32'h0F0F_F0F0);
    tx_en_mask = '1;
    op("R7", 1, 0, 0, 0);
    chk("R7 upper read", {16'h0, bus_rdata}, 32'h0F0F);
    tx_done = 32'h0000_00F0; op("R7", 0, 0, 0, 0);
    op("R7", 1, 0, 1, 0);
    chk("R7 snapshot", {16'h0, bus_rdata}, 32'hF0F0);
    op("R8", 1, 0, 1, 0);
    chk("R8 lone lower read", {16'h0, bus_rdata}, 32'hF0F0);
    op("R9", 0, 0, 0, 0);
    op("R9", 1, 1, 1, 16'h0000);
    chk("R9 rdata held", {16'h0, bus_rdata}, 32'hF0F0);
    op("R8", 1, 1, 0, 16'h1234);
    op("R8", 1, 0, 1, 0);
    chk("R8 shared latch", {16'h0, bus_rdata}, 32'h1234);
    for (int i = 0; i < 400; i++) begin
      tx_en_mask = ($urandom % 4 == 0) ? $urandom : '1;
      if ($urandom % 6 == 0) cancel_req = 32'h1 << ($urandom % 32);
      if ($urandom % 6 == 0) tx_done = 32'h1 << ($urandom % 32);
      op("RND", $urandom % 4 != 0, $urandom % 2, $urandom % 2, $urandom);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule